// File: doc/BRIEF.md
# Block Address Translation Matcher

This block translates an effective address through a small set of block translation entries. Each entry covers a power-of-two-aligned block. It holds a mask that selects the compared address bits, a base value those bits must equal, a real base that replaces them, a two-bit protection code, and two valid bits, one per privilege level. There are two separate banks of entries. One serves instruction fetches and the other serves data accesses. A side-select input on each request chooses the bank.

A caller presents a request with the address, the bank select, the privilege level and a write flag. One cycle later the block returns either a hit, or a miss that tells the caller to fall back to page-table translation. A hit carries the translated address, the read, write and execute grants, and the number of the winning entry. An entry that matches but refuses the access is passed over, and the search goes on to the higher-numbered entries. Entries are loaded through a single-cycle write port that replaces a whole entry at once.

Top module: `bat_matcher`

## Requirements
- R1: After reset, `rspValid` is 0 and every entry in both banks is invalid, so any lookup misses.
- R2: A request accepted with `reqValid`=1 at a clock edge produces `rspValid`=1 for exactly the following cycle. In cycles with no response, `rspHit`, `rspMiss` and `rspAddr` are all 0.
- R3: `reqDataSide`=1 searches the data bank and `reqDataSide`=0 searches the instruction bank. `wrDataSide` picks the bank a write goes to, with the same encoding.
- R4: When `reqUser`=1, an entry takes part only if its user-valid bit is set. When `reqUser`=0, an entry takes part only if its supervisor-valid bit is set.
- R5: An entry matches when `(reqAddr & mask) == base`.
- R6: On a hit, `rspAddr = real | (reqAddr & ~mask)`, using the winning entry's fields.
- R7: Protection code 0 grants nothing. Code 1 grants read only. Codes 2 and 3 grant read and write. On a hit, `rspExec` is 1.
- R8: A matching entry with protection 0 is skipped. A matching entry with protection 1 is skipped when `reqWrite`=1. In both cases the search continues with the later entries.
- R9: Among the entries that qualify, the lowest-numbered one wins, and `rspEntry` reports its index.
- R10: When no entry qualifies, the response has `rspMiss`=1 and `rspHit`=0. `rspAddr`, all the grants and `rspEntry` are 0.
- R11: An entry write becomes visible to the next lookup. A lookup in the same cycle as a write sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | ADDR_W | Effective address |
| reqDataSide | input | 1 | 1 = data bank, 0 = instruction bank |
| reqUser | input | 1 | 1 = user mode, 0 = supervisor |
| reqWrite | input | 1 | Access is a store |
| wrEn | input | 1 | Entry write strobe |
| wrDataSide | input | 1 | Bank written: 1 = data, 0 = instruction |
| wrIdx | input | IDX_W | Entry number written |
| wrMask | input | ADDR_W | Block mask |
| wrBase | input | ADDR_W | Block effective base |
| wrReal | input | ADDR_W | Block real base |
| wrProt | input | 2 | Protection code |
| wrSupValid | input | 1 | Valid in supervisor mode |
| wrUserValid | input | 1 | Valid in user mode |
| rspValid | output | 1 | Response present |
| rspHit | output | 1 | Translation found |
| rspMiss | output | 1 | No entry qualified; use the page table |
| rspAddr | output | ADDR_W | Translated real address |
| rspRead | output | 1 | Read granted |
| rspWrite | output | 1 | Write granted |
| rspExec | output | 1 | Execute granted |
| rspEntry | output | IDX_W | Index of the winning entry |

## Verification
The lookup is tried with addresses that sit inside and outside a block, under both privilege levels and on both bank selects. These patterns separate the match logic, the valid-bit choice and the bank choice. Overlapping entries with different protection codes are looked up with both reads and stores. This shows whether a refused match is skipped or ends the search, and whether the lowest index wins. A nested pair of blocks, one small and one large, is probed inside and outside the small block, which tells the mask-driven real-address splice apart from priority effects. A write issued in the same cycle as a lookup, followed by a repeat of that lookup, shows when a new entry becomes visible.

// File: rtl/bat_pkg.sv
`timescale 1ns/1ps
package bat_pkg;
  localparam int NUM_BANKS = 2;
  localparam int BANK_INSTR = 0;
  localparam int BANK_DATA = 1;

  typedef struct packed {
    logic loadRsp;
    logic wrInstr;
    logic wrData;
  } batCtrl_t;
endpackage

// File: rtl/bat_ctrl.sv
`timescale 1ns/1ps
module bat_ctrl
  import bat_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     reqValid,
  input  logic     wrEn,
  input  logic     wrDataSide,
  output batCtrl_t ctrl,
  output logic     rspValid
);
  always_comb begin
    ctrl.loadRsp = reqValid;
    ctrl.wrInstr = wrEn & ~wrDataSide;
    ctrl.wrData  = wrEn & wrDataSide;
  end

  always_ff @(posedge clk) begin
    if (rst) rspValid <= 1'b0;
    else     rspValid <= reqValid;
  end
endmodule

// File: rtl/bat_entry_eval.sv
`timescale 1ns/1ps
module bat_entry_eval #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              user,
  input  logic              write,
  input  logic [ADDR_W-1:0] mask,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] realBase,
  input  logic [1:0]        prot,
  input  logic              supValid,
  input  logic              userValid,
  output logic              qualify,
  output logic              canWrite,
  output logic [ADDR_W-1:0] realAddr
);
  logic levelOk, hitMatch, readable;

  always_comb begin
    levelOk  = user ? userValid : supValid;
    hitMatch = (addr & mask) == base;
    readable = prot != 2'd0;
    canWrite = prot[1];
    qualify  = levelOk && hitMatch && readable && (!write || canWrite);
    realAddr = realBase | (addr & ~mask);
  end
endmodule

// File: rtl/bat_datapath.sv
`timescale 1ns/1ps
module bat_datapath
  import bat_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  batCtrl_t          ctrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqDataSide,
  input  logic              reqUser,
  input  logic              reqWrite,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrMask,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [ADDR_W-1:0] wrReal,
  input  logic [1:0]        wrProt,
  input  logic              wrSupValid,
  input  logic              wrUserValid,
  output logic              rspHit,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspRead,
  output logic              rspWrite,
  output logic              rspExec,
  output logic [IDX_W-1:0]  rspEntry
);
  logic [ADDR_W-1:0] maskQ  [NUM_BANKS][NUM_ENTRIES];
  logic [ADDR_W-1:0] baseQ  [NUM_BANKS][NUM_ENTRIES];
  logic [ADDR_W-1:0] realQ  [NUM_BANKS][NUM_ENTRIES];
  logic [1:0]        protQ  [NUM_BANKS][NUM_ENTRIES];
  logic              supVQ  [NUM_BANKS][NUM_ENTRIES];
  logic              userVQ [NUM_BANKS][NUM_ENTRIES];

  logic [NUM_ENTRIES-1:0] qualify;
  logic [NUM_ENTRIES-1:0] canWrite;
  logic [ADDR_W-1:0]      entryAddr [NUM_ENTRIES];

  // Entry storage, one register set per bank and entry.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bankWr;
    assign bankWr = (b == BANK_DATA) ? ctrl.wrData : ctrl.wrInstr;
    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
      always_ff @(posedge clk) begin
        if (rst) begin
          maskQ[b][e]  <= '0;
          baseQ[b][e]  <= '0;
          realQ[b][e]  <= '0;
          protQ[b][e]  <= 2'd0;
          supVQ[b][e]  <= 1'b0;
          userVQ[b][e] <= 1'b0;
        end else if (bankWr && wrIdx == IDX_W'(e)) begin
          maskQ[b][e]  <= wrMask;
          baseQ[b][e]  <= wrBase;
          realQ[b][e]  <= wrReal;
          protQ[b][e]  <= wrProt;
          supVQ[b][e]  <= wrSupValid;
          userVQ[b][e] <= wrUserValid;
        end
      end
    end
  end

  // Per-entry evaluation against the selected bank.
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_eval
    logic bankSel;
    assign bankSel = reqDataSide;
    bat_entry_eval #(.ADDR_W(ADDR_W)) u_eval (
      .addr      (reqAddr),
      .user      (reqUser),
      .write     (reqWrite),
      .mask      (bankSel ? maskQ[BANK_DATA][e]  : maskQ[BANK_INSTR][e]),
      .base      (bankSel ? baseQ[BANK_DATA][e]  : baseQ[BANK_INSTR][e]),
      .realBase  (bankSel ? realQ[BANK_DATA][e]  : realQ[BANK_INSTR][e]),
      .prot      (bankSel ? protQ[BANK_DATA][e]  : protQ[BANK_INSTR][e]),
      .supValid  (bankSel ? supVQ[BANK_DATA][e]  : supVQ[BANK_INSTR][e]),
      .userValid (bankSel ? userVQ[BANK_DATA][e] : userVQ[BANK_INSTR][e]),
      .qualify   (qualify[e]),
      .canWrite  (canWrite[e]),
      .realAddr  (entryAddr[e])
    );
  end

  // Lowest-numbered qualifying entry wins.
  logic              found;
  logic [IDX_W-1:0]  foundIdx;
  logic [ADDR_W-1:0] foundAddr;
  logic              foundWr;

  always_comb begin
    found     = 1'b0;
    foundIdx  = '0;
    foundAddr = '0;
    foundWr   = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (qualify[i]) begin
        found     = 1'b1;
        foundIdx  = IDX_W'(i);
        foundAddr = entryAddr[i];
        foundWr   = canWrite[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !ctrl.loadRsp) begin
      rspHit   <= 1'b0;
      rspAddr  <= '0;
      rspRead  <= 1'b0;
      rspWrite <= 1'b0;
      rspExec  <= 1'b0;
      rspEntry <= '0;
    end else begin
      rspHit   <= found;
      rspAddr  <= foundAddr;
      rspRead  <= found;
      rspWrite <= found & foundWr;
      rspExec  <= found;
      rspEntry <= foundIdx;
    end
  end
endmodule

// File: rtl/bat_matcher.sv
`timescale 1ns/1ps
module bat_matcher
  import bat_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_ENTRIES = 8,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqDataSide,
  input  logic              reqUser,
  input  logic              reqWrite,
  input  logic              wrEn,
  input  logic              wrDataSide,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrMask,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [ADDR_W-1:0] wrReal,
  input  logic [1:0]        wrProt,
  input  logic              wrSupValid,
  input  logic              wrUserValid,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspMiss,
  output logic [ADDR_W-1:0] rspAddr,
  output logic              rspRead,
  output logic              rspWrite,
  output logic              rspExec,
  output logic [IDX_W-1:0]  rspEntry
);
  batCtrl_t ctrl;

  bat_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .reqValid   (reqValid),
    .wrEn       (wrEn),
    .wrDataSide (wrDataSide),
    .ctrl       (ctrl),
    .rspValid   (rspValid)
  );

  bat_datapath #(.ADDR_W(ADDR_W), .NUM_ENTRIES(NUM_ENTRIES)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .ctrl        (ctrl),
    .reqAddr     (reqAddr),
    .reqDataSide (reqDataSide),
    .reqUser     (reqUser),
    .reqWrite    (reqWrite),
    .wrIdx       (wrIdx),
    .wrMask      (wrMask),
    .wrBase      (wrBase),
    .wrReal      (wrReal),
    .wrProt      (wrProt),
    .wrSupValid  (wrSupValid),
    .wrUserValid (wrUserValid),
    .rspHit      (rspHit),
    .rspAddr     (rspAddr),
    .rspRead     (rspRead),
    .rspWrite    (rspWrite),
    .rspExec     (rspExec),
    .rspEntry    (rspEntry)
  );

  assign rspMiss = rspValid & ~rspHit;
endmodule

// File: rtl/bat_matcher_chk.sv
`timescale 1ns/1ps
module bat_matcher_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              rspValid,
  input logic              rspHit,
  input logic              rspMiss,
  input logic [ADDR_W-1:0] rspAddr,
  input logic              rspRead,
  input logic              rspWrite,
  input logic              rspExec,
  input logic [IDX_W-1:0]  rspEntry
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rspValid |-> (!rspHit && !rspMiss && rspAddr == '0)); // R2
  AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> (rspHit != rspMiss)); // R10
  AST_HIT_GRANTS: assert property (@(posedge clk) disable iff (rst)
    rspHit |-> (rspRead && rspExec)); // R7
  AST_STORE_GRANTED: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqWrite) |=> (!rspHit || rspWrite)); // R8
  AST_MISS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    rspMiss |-> (rspAddr == '0 && !rspRead && !rspWrite && !rspExec && rspEntry == '0)); // R10
endmodule

bind bat_matcher bat_matcher_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/bat_matcher_tb.sv
`timescale 1ns/1ps
module bat_matcher_tb;
  localparam int AW = 32;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reqValid = 0, reqDataSide = 0, reqUser = 0, reqWrite = 0;
  logic [AW-1:0] reqAddr = '0;
  logic          wrEn = 0, wrDataSide = 0, wrSupValid = 0, wrUserValid = 0;
  logic [IW-1:0] wrIdx = '0;
  logic [AW-1:0] wrMask = '0, wrBase = '0, wrReal = '0;
  logic [1:0]    wrProt = '0;
  logic          rspValid, rspHit, rspMiss, rspRead, rspWrite, rspExec;
  logic [AW-1:0] rspAddr;
  logic [IW-1:0] rspEntry;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bat_matcher u_dut (.*);

  task automatic chk(string tag, logic [40:0] act, logic [40:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [40:0] rspVec();
    return {rspValid, rspHit, rspMiss, rspAddr, rspRead, rspWrite, rspExec, rspEntry};
  endfunction

  function automatic logic [40:0] hitVec(logic [AW-1:0] a, logic w, logic [IW-1:0] idx);
    return {1'b1, 1'b1, 1'b0, a, 1'b1, w, 1'b1, idx};
  endfunction

  localparam logic [40:0] MISS_VEC = {1'b1, 1'b0, 1'b1, 32'h0, 3'b000, 3'd0};
  localparam logic [40:0] IDLE_VEC = '0;

  task automatic writeEntry(logic side, logic [IW-1:0] idx, logic [AW-1:0] m,
                            logic [AW-1:0] b, logic [AW-1:0] r, logic [1:0] p,
                            logic sv, logic uv);
    @(negedge clk);
    wrEn = 1; wrDataSide = side; wrIdx = idx; wrMask = m; wrBase = b;
    wrReal = r; wrProt = p; wrSupValid = sv; wrUserValid = uv;
    @(negedge clk);
    wrEn = 0;
  endtask

  // Drive at a negedge; result is registered at the next posedge and sampled at the following negedge.
  task automatic lookup(logic [AW-1:0] a, logic side, logic user, logic w);
    @(negedge clk);
    reqValid = 1; reqAddr = a; reqDataSide = side; reqUser = user; reqWrite = w;
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset idle", rspVec(), IDLE_VEC);
    lookup(32'h1234_5678, 1, 0, 0);
    chk("R1 data bank empty", rspVec(), MISS_VEC);
    lookup(32'h0000_0000, 0, 1, 0);
    chk("R1 instr bank empty", rspVec(), MISS_VEC);
  endtask

  task automatic t_basic();
    writeEntry(1, 0, 32'hF000_0000, 32'h3000_0000, 32'h8000_0000, 2'd2, 1, 0);
    lookup(32'h3123_4567, 1, 0, 1);
    chk("R5 R6 R7 data hit", rspVec(), hitVec(32'h8123_4567, 1, 0));
    lookup(32'h4000_0000, 1, 0, 0);
    chk("R5 outside block", rspVec(), MISS_VEC);
    lookup(32'h3123_4567, 0, 0, 0);
    chk("R3 instr bank separate", rspVec(), MISS_VEC);
    lookup(32'h3123_4567, 1, 1, 0);
    chk("R4 user not valid", rspVec(), MISS_VEC);
  endtask

  task automatic t_user();
    writeEntry(0, 2, 32'hFFFE_0000, 32'h0002_0000, 32'h0100_0000, 2'd1, 0, 1);
    lookup(32'h0003_1ABC, 0, 1, 0);
    chk("R4 R7 user read-only hit", rspVec(), hitVec(32'h0101_1ABC, 0, 2));
    lookup(32'h0003_1ABC, 0, 0, 0);
    chk("R4 supervisor not valid", rspVec(), MISS_VEC);
    lookup(32'h0003_1ABC, 0, 1, 1);
    chk("R8 store to read-only skipped", rspVec(), MISS_VEC);
  endtask

  task automatic t_skip();
    writeEntry(1, 1, 32'hFF00_0000, 32'h5000_0000, 32'hA000_0000, 2'd0, 1, 0);
    writeEntry(1, 3, 32'hFF00_0000, 32'h5000_0000, 32'hB000_0000, 2'd1, 1, 0);
    writeEntry(1, 5, 32'hFF00_0000, 32'h5000_0000, 32'hC000_0000, 2'd3, 1, 0);
    lookup(32'h5012_3456, 1, 0, 0);
    chk("R8 prot0 skipped", rspVec(), hitVec(32'hB012_3456, 0, 3));
    lookup(32'h5012_3456, 1, 0, 1);
    chk("R8 store passes read-only", rspVec(), hitVec(32'hC012_3456, 1, 5));
  endtask

  task automatic t_priority();
    writeEntry(1, 6, 32'hFFF0_0000, 32'h7000_0000, 32'h0600_0000, 2'd2, 1, 1);
    writeEntry(1, 7, 32'hF000_0000, 32'h7000_0000, 32'h2000_0000, 2'd2, 1, 1);
    lookup(32'h7001_2345, 1, 0, 0);
    chk("R9 lowest index wins", rspVec(), hitVec(32'h0601_2345, 1, 6));
    lookup(32'h7801_2345, 1, 1, 0);
    chk("R9 R6 wide block", rspVec(), hitVec(32'h2801_2345, 1, 7));
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    wrEn = 1; wrDataSide = 0; wrIdx = 0; wrMask = 32'hFFFF_F000;
    wrBase = 32'h0000_1000; wrReal = 32'h0009_9000; wrProt = 2'd3;
    wrSupValid = 1; wrUserValid = 0;
    reqValid = 1; reqAddr = 32'h0000_1ABC; reqDataSide = 0; reqUser = 0; reqWrite = 0;
    @(negedge clk);
    wrEn = 0; reqValid = 0;
    chk("R11 same-cycle sees old", rspVec(), MISS_VEC);
    lookup(32'h0000_1ABC, 0, 0, 1);
    chk("R11 next lookup sees new", rspVec(), hitVec(32'h0009_9ABC, 1, 0));
  endtask

  task automatic t_idle();
    @(negedge clk);
    chk("R2 no response when idle", rspVec(), IDLE_VEC);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_basic();
    t_user();
    t_skip();
    t_priority();
    t_same_cycle();
    t_idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule